// File: doc/BRIEF.md
# DSP Position-Field Conditional Branch Unit

This block sits beside the decode stage of an in-order pipeline. It recognises one PC-relative conditional branch encoding in the 32-bit instruction stream. The branch is decided by the bit-position field of the DSP control register rather than by comparing general registers. At decode time the block forms the target address. It samples the position field and arms a one-instruction delay slot.

The branch takes effect only after the instruction that follows it has issued. When the next valid instruction (the delay-slot instruction) issues, the block asks fetch to redirect in the following cycle, provided the branch was taken. If that slot instruction is itself a control transfer, the block raises a reserved-instruction trap instead, and the redirect is dropped. If the DSP unit is disabled when the branch is decoded, the block raises a DSP-disabled trap and does not arm the branch.

Top module: `posbr_unit`

## Requirements
- R1: `decodeHit` is high in the same cycle exactly when `instValid` is high, bits [31:26] equal 000001, bits [25:21] equal 00000 and bits [20:16] equal 11100.
- R2: After a branch is accepted with DSP enabled, `branchTarget` shows `instPc + 4 + sext(offset[15:0] << 2)` from the next cycle on, wrapping at `ADDR_W` bits. It holds that value until the next accepted branch, and it is zero after reset.
- R3: An accepted branch counts as taken exactly when the 7-bit `posField`, read as unsigned, is 32 or greater.
- R4: For a taken branch, `redirect` is a one-cycle pulse in the cycle after the next `instValid` cycle (the delay slot). Cycles without `instValid` in between postpone it, and it is never raised for a not-taken branch.
- R5: A delay-slot instruction flagged by `isCtrlXfer`, or decoded as this branch, gives a one-cycle `excReserved` pulse in the following cycle and no `redirect`.
- R6: A branch decoded while `dspEnable` is low gives a one-cycle `excDspOff` pulse in the next cycle and arms no delay slot, so the next instruction causes no `redirect`.
- R7: The taken decision uses the `posField` value present in the branch's decode cycle. Later changes have no effect on it.
- R8: A synchronous active-high `rst` clears any armed delay slot and holds `redirect`, `excReserved` and `excDspOff` low in the cycle after it is sampled.
- R9: `isCtrlXfer` outside a delay slot raises no exception and causes no redirect.
- R10: A branch decoded inside a delay slot is trapped as in R5 and does not arm a new delay slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | 1 | An instruction issues this cycle |
| instWord | input | 32 | Issuing instruction word |
| instPc | input | ADDR_W | Address of the issuing instruction |
| posField | input | 7 | Position field of the DSP control register |
| dspEnable | input | 1 | DSP unit enabled |
| isCtrlXfer | input | 1 | Issuing word is some other control transfer |
| decodeHit | output | 1 | Issuing word is the position branch |
| branchTarget | output | ADDR_W | Captured branch target |
| redirect | output | 1 | Fetch redirect pulse after the delay slot |
| excReserved | output | 1 | Reserved-instruction trap pulse |
| excDspOff | output | 1 | DSP-disabled trap pulse |

## Verification
The bench hits both sides of the threshold at 31, 32 and 127. A comparator that was off by one, or signed, would flip the taken decision at one of these values. Negative and maximum offsets, including one that wraps below address zero, expose a missing sign extension or a wrong base address as a wrong `branchTarget`.

Idle gaps between a branch and its slot show up a design that counts cycles instead of instructions: its `redirect` comes early. A change of `posField` after decode catches a design that reads the field live instead of the captured value. The bench also puts a branch inside a slot, a flagged transfer inside a slot, a branch with DSP disabled, and a reset while a slot is armed. A design that kept the slot armed in any of these cases would raise a `redirect` where none is allowed.

// File: rtl/posbr_pkg.sv
package posbr_pkg;

  localparam int INST_W      = 32;
  localparam int POS_W       = 7;
  localparam int POS_THRESH  = 32;
  localparam int OFF_W       = 16;
  localparam int OFF_SHIFT   = 2;
  localparam int OFF_EXT_W   = OFF_W + OFF_SHIFT;
  localparam int INST_BYTES  = 4;

  localparam logic [5:0] MAJOR_REGIMM = 6'b000001;
  localparam logic [4:0] SUB_POSBR    = 5'b11100;
  localparam logic [4:0] RS_ZERO      = 5'b00000;

  typedef struct packed {
    logic capture;
    logic slotDone;
  } posbr_strobe_t;

  typedef struct packed {
    logic hit;
    logic takenQ;
  } posbr_status_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SLOT = 1'b1
  } posbr_state_t;

endpackage

// File: rtl/posbr_datapath.sv
module posbr_datapath
  import posbr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                instValid,
  input  logic [INST_W-1:0]   instWord,
  input  logic [ADDR_W-1:0]   instPc,
  input  logic [POS_W-1:0]    posField,
  input  posbr_strobe_t       strobe,
  output posbr_status_t       status,
  output logic [ADDR_W-1:0]   branchTarget
);

  localparam int SEXT_W = ADDR_W - OFF_EXT_W;

  logic              majorOk, rsOk, subOk;
  logic              condNow;
  logic [ADDR_W-1:0] seqPc;
  logic [ADDR_W-1:0] offExt;
  logic [ADDR_W-1:0] targetNow;
  logic [ADDR_W-1:0] targetQ;
  logic              takenQ;

  // Field decode of the issuing word
  always_comb begin
    majorOk = (instWord[31:26] == MAJOR_REGIMM);
    rsOk    = (instWord[25:21] == RS_ZERO);
    subOk   = (instWord[20:16] == SUB_POSBR);
  end

  // Offset widening: generate picks the plain path when no extension bits are needed
  generate
    if (SEXT_W > 0) begin : g_sext
      assign offExt = {{SEXT_W{instWord[OFF_W-1]}}, instWord[OFF_W-1:0], {OFF_SHIFT{1'b0}}};
    end else begin : g_nosext
      logic [OFF_EXT_W-1:0] offWide;
      assign offWide = {instWord[OFF_W-1:0], {OFF_SHIFT{1'b0}}};
      assign offExt  = offWide[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    seqPc     = instPc + ADDR_W'(INST_BYTES);
    targetNow = seqPc + offExt;
    condNow   = ({1'b0, posField} >= (POS_W+1)'(POS_THRESH));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      targetQ <= '0;
      takenQ  <= 1'b0;
    end else if (strobe.capture) begin
      targetQ <= targetNow;
      takenQ  <= condNow;
    end
  end

  always_comb begin
    status.hit    = instValid && majorOk && rsOk && subOk;
    status.takenQ = takenQ;
    branchTarget  = targetQ;
  end

  // R2: the target register moves only on a capture strobe
  a_r2_target_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.capture |=> $stable(targetQ));

  // R7: the captured decision is frozen between captures
  a_r7_taken_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.capture |=> $stable(takenQ));

  // R1: a capture request only follows a hit
  a_r1_capture_on_hit: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |-> status.hit);

endmodule

// File: rtl/posbr_control.sv
module posbr_control
  import posbr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          instValid,
  input  logic          dspEnable,
  input  logic          isCtrlXfer,
  input  posbr_status_t status,
  output posbr_strobe_t strobe,
  output logic          redirect,
  output logic          excReserved,
  output logic          excDspOff
);

  posbr_state_t state, stateNext;
  logic inSlot, slotIssue, slotTrap, newBranch;
  logic redirectQ, excResQ, excDspQ;

  always_comb begin
    inSlot    = (state == ST_SLOT);
    slotIssue = instValid && inSlot;
    slotTrap  = slotIssue && (isCtrlXfer || status.hit);
    newBranch = status.hit && !inSlot;
    strobe.capture  = newBranch && dspEnable;
    strobe.slotDone = slotIssue;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strobe.capture)  stateNext = ST_SLOT;
      ST_SLOT: if (strobe.slotDone) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      redirectQ <= 1'b0;
      excResQ   <= 1'b0;
      excDspQ   <= 1'b0;
    end else begin
      state     <= stateNext;
      redirectQ <= slotIssue && !slotTrap && status.takenQ;
      excResQ   <= slotTrap;
      excDspQ   <= newBranch && !dspEnable;
    end
  end

  always_comb begin
    redirect    = redirectQ;
    excReserved = excResQ;
    excDspOff   = excDspQ;
  end

  // R4: a redirect follows an issued delay-slot instruction
  a_r4_after_slot: assert property (@(posedge clk) disable iff (rst)
    redirect |-> $past(slotIssue));

  // R4: redirect is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !redirect);

  // R5: a trapped slot never redirects
  a_r5_trap_excl: assert property (@(posedge clk) disable iff (rst)
    !(redirect && excReserved));

  // R6: a DSP-disabled trap leaves no slot armed
  a_r6_not_armed: assert property (@(posedge clk) disable iff (rst)
    excDspOff |-> (state == ST_IDLE));

  // R10: a trapped slot returns to idle
  a_r10_trap_idle: assert property (@(posedge clk) disable iff (rst)
    excReserved |-> (state == ST_IDLE));

endmodule

// File: rtl/posbr_unit.sv
module posbr_unit
  import posbr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic [ADDR_W-1:0] instPc,
  input  logic [6:0]        posField,
  input  logic              dspEnable,
  input  logic              isCtrlXfer,
  output logic              decodeHit,
  output logic [ADDR_W-1:0] branchTarget,
  output logic              redirect,
  output logic              excReserved,
  output logic              excDspOff
);

  posbr_strobe_t strobe;
  posbr_status_t status;

  posbr_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .instValid    (instValid),
    .instWord     (instWord),
    .instPc       (instPc),
    .posField     (posField),
    .strobe       (strobe),
    .status       (status),
    .branchTarget (branchTarget)
  );

  posbr_control u_ctl (
    .clk         (clk),
    .rst         (rst),
    .instValid   (instValid),
    .dspEnable   (dspEnable),
    .isCtrlXfer  (isCtrlXfer),
    .status      (status),
    .strobe      (strobe),
    .redirect    (redirect),
    .excReserved (excReserved),
    .excDspOff   (excDspOff)
  );

  assign decodeHit = status.hit;

endmodule

// File: tb/sim_posbr_unit.sv
module sim_posbr_unit;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst, instValid, dspEnable, isCtrlXfer;
  logic [31:0]   instWord;
  logic [AW-1:0] instPc;
  logic [6:0]    posField;
  logic          decodeHit, redirect, excReserved, excDspOff;
  logic [AW-1:0] branchTarget;

  always #2.5 clk = ~clk;

  posbr_unit #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .instPc(instPc), .posField(posField), .dspEnable(dspEnable),
    .isCtrlXfer(isCtrlXfer), .decodeHit(decodeHit), .branchTarget(branchTarget),
    .redirect(redirect), .excReserved(excReserved), .excDspOff(excDspOff)
  );

  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;
  string tag   = "reset";

  // reference model state
  bit          mPend  = 0;
  bit          mTaken = 0;
  logic [AW-1:0] mTarget = '0;
  bit          eRed = 0, eRes = 0, eDsp = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h", req, tag, what, act, exp);
    end
  endtask

  function automatic bit isBr(logic [31:0] w);
    return (w[31:26] == 6'd1) && (w[25:21] == 5'd0) && (w[20:16] == 5'd28);
  endfunction

  function automatic logic [31:0] br(logic [15:0] off);
    return {6'd1, 5'd0, 5'd28, off};
  endfunction

  task automatic step(bit r, bit v, logic [31:0] w, logic [AW-1:0] pc,
                      logic [6:0] pos, bit en, bit cx);
    bit hit, slot, trap;
    longint t;
    @(negedge clk);
    chk("R4", "redirect", redirect, eRed);
    chk("R5", "excReserved", excReserved, eRes);
    chk("R6", "excDspOff", excDspOff, eDsp);
    chk("R2", "branchTarget", branchTarget, mTarget);
    rst = r; instValid = v; instWord = w; instPc = pc;
    posField = pos; dspEnable = en; isCtrlXfer = cx;
    #1;
    hit = v && isBr(w);
    chk("R1", "decodeHit", decodeHit, hit);
    if (r) begin
      mPend = 0; mTaken = 0; mTarget = '0; eRed = 0; eRes = 0; eDsp = 0;
    end else begin
      slot = v && mPend;
      trap = slot && (cx || hit);
      eRed = slot && !trap && mTaken;
      eRes = trap;
      eDsp = hit && !mPend && !en;
      if (hit && !mPend && en) begin
        t = longint'(pc) + 4 + longint'($signed(w[15:0])) * 4;
        mTarget = t[AW-1:0];
        mTaken  = (int'(pos) >= 32);
        mPend   = 1;
      end else if (slot) begin
        mPend = 0;
      end
    end
  endtask

  task automatic op(logic [AW-1:0] pc, logic [6:0] pos = 7'd0);
    step(0, 1, 32'h0128_4020, pc, pos, 1, 0);
  endtask

  task automatic gap();
    step(0, 0, 32'h0, '0, 7'd0, 1, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; instValid = 0; instWord = 0; instPc = 0; posField = 0;
    dspEnable = 1; isCtrlXfer = 0;
    // R8: outputs quiet under reset
    tag = "R8 reset";
    step(1, 1, br(16'h0004), 32'h100, 7'd40, 1, 0);
    step(1, 0, 0, 0, 0, 1, 0);
    @(negedge clk);
    chk("R8", "redirect after reset", redirect, 0);
    chk("R8", "excReserved after reset", excReserved, 0);
    chk("R8", "excDspOff after reset", excDspOff, 0);

    tag = "R1 near misses";
    step(0, 1, {6'd1, 5'd1, 5'd28, 16'h0}, 32'h200, 7'd40, 1, 0);
    step(0, 1, {6'd1, 5'd0, 5'd29, 16'h0}, 32'h204, 7'd40, 1, 0);
    step(0, 1, {6'd3, 5'd0, 5'd28, 16'h0}, 32'h208, 7'd40, 1, 0);
    step(0, 0, br(16'h0010), 32'h20C, 7'd40, 1, 0);
    op(32'h210);

    tag = "R3 pos=32 taken";
    step(0, 1, br(16'h0010), 32'h1000, 7'd32, 1, 0);
    op(32'h1004); gap(); gap();

    tag = "R3 pos=31 not taken";
    step(0, 1, br(16'h0020), 32'h2000, 7'd31, 1, 0);
    op(32'h2004, 7'd64); gap();

    tag = "R2 negative wrap pos=127";
    step(0, 1, br(16'h8000), 32'h0000_0010, 7'd127, 1, 0);
    op(32'h14); gap();

    tag = "R2 max offset";
    step(0, 1, br(16'h7FFF), 32'hFFFF_FFF0, 7'd33, 1, 0);
    op(32'hFFFF_FFF4); gap();

    tag = "R4 gaps before slot";
    step(0, 1, br(16'h0001), 32'h3000, 7'd50, 1, 0);
    gap(); gap(); gap();
    op(32'h3004); gap();

    tag = "R7 pos changes after decode";
    step(0, 1, br(16'h0002), 32'h4000, 7'd40, 1, 0);
    gap();
    op(32'h4004, 7'd0); gap();
    step(0, 1, br(16'h0002), 32'h4100, 7'd5, 1, 0);
    op(32'h4104, 7'd100); gap();

    tag = "R5 flagged transfer in slot";
    step(0, 1, br(16'h0003), 32'h5000, 7'd40, 1, 0);
    step(0, 1, 32'h0800_0000, 32'h5004, 7'd40, 1, 1);
    op(32'h5008); gap();

    tag = "R10 branch in slot";
    step(0, 1, br(16'h0003), 32'h5100, 7'd40, 1, 0);
    step(0, 1, br(16'h0040), 32'h5104, 7'd40, 1, 0);
    op(32'h5108); op(32'h510C); gap();

    tag = "R6 dsp disabled";
    step(0, 1, br(16'h0005), 32'h6000, 7'd40, 0, 0);
    op(32'h6004); op(32'h6008); gap();

    tag = "R9 transfer outside slot";
    step(0, 1, 32'h0800_0000, 32'h7000, 7'd40, 1, 1);
    op(32'h7004); gap();

    tag = "R8 reset while armed";
    step(0, 1, br(16'h0006), 32'h8000, 7'd40, 1, 0);
    step(1, 0, 0, 0, 7'd40, 1, 0);
    op(32'h8004); gap();
    @(negedge clk);
    chk("R8", "no redirect after reset", redirect, 0);

    tag = "R4 back to back";
    step(0, 1, br(16'h0008), 32'h9000, 7'd32, 1, 0);
    op(32'h9004);
    step(0, 1, br(16'hFFF8), 32'h9028, 7'd90, 1, 0);
    op(32'h902C); gap(); gap();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule